// File: doc/BRIEF.md
# Paged Receive Ring Store

This block is the receive-side store of a network controller. Incoming frames arrive as a stream of bytes, one per cycle, closed by an end-of-frame strobe that says whether the frame was good. The block writes each frame into a circular region of buffer memory. The region is divided into 256-byte pages and is bounded by a start page and a stop page. A current page register is the write pointer. A boundary page register is the read pointer, and the host owns it.

The payload of each frame begins four bytes into the current page and runs on through as many pages as the frame needs. Once the payload is stored and the frame is good, the block goes back and fills the four reserved bytes with a header. The header holds the status, the page where the following frame will start, and the total byte count. It then moves the current page to that following page and raises a one-cycle packet-received interrupt.

If the write side would enter the page held in the boundary register, the frame is abandoned and a one-cycle overwrite warning is raised. A frame that ends in error is dropped, and its space is reused by the next frame. The host frees space by moving the boundary. It reads the ring fill state from the empty flag and the two pointer outputs.

Top module: `pgring_rx`

## Requirements
- R1: After reset the start and stop pages take their parameter values, the boundary equals the start page, the current page equals start plus 1, the empty flag is 1, and neither the interrupt nor the warning is asserted.
- R2: Payload byte k of a frame is written to page-relative position 4+k counted from the current page (address = page*256 + offset). It crosses into following pages, and the page after stop-1 is the start page.
- R3: The header is written at offsets 0..3 of the current page: byte 0 status, byte 1 next-frame page, byte 2 count bits 7:0, byte 3 count bits 15:8. The count is the payload length plus 4. In the status byte, bit 0 (frame intact) is 1 and bit 3 copies the FIFO-overrun input sampled with the end strobe; all other bits are 0.
- R4: For a good frame, the next-frame page is the current page advanced by ceil(count/256) pages around the ring. After the four header writes the current page takes that value and the interrupt is high for exactly one cycle.
- R5: A frame closed with the good flag low raises no interrupt and leaves the current page unchanged.
- R6: When a payload byte would be written at offset 0 of a page equal to the boundary, that byte and the rest of the frame are not written. The warning is high for one cycle, and no interrupt follows. The current page is unchanged.
- R7: The empty flag is 1 exactly when the current page equals boundary plus 1, where boundary plus 1 wraps from the stop page to the start page.
- R8: A host write with select 0 (start), 1 (stop), 2 (boundary) or 3 (current) takes effect on the next cycle. A current-page update from a frame commit in the same cycle overrides a host write to the current page. The boundary check of R6 uses the boundary held before a same-cycle host write.
- R9: A frame whose count ends exactly at a page end claims no further page. It raises no warning even when the page after it is the boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| rx_valid_i | input | 1 | A frame byte is present this cycle |
| rx_data_i | input | DW | Frame byte |
| rx_eof_i | input | 1 | End-of-frame strobe (carries no byte) |
| rx_good_i | input | 1 | Frame good, sampled with the end strobe |
| rx_fovr_i | input | 1 | FIFO overrun seen, sampled with the end strobe |
| host_we_i | input | 1 | Host register write strobe |
| host_sel_i | input | 2 | Register select: 0 start, 1 stop, 2 boundary, 3 current |
| host_wdata_i | input | PW | Page number to write |
| mem_we_o | output | 1 | Buffer memory write enable |
| mem_addr_o | output | PW+OW | Buffer memory byte address |
| mem_wdata_o | output | DW | Buffer memory write data |
| irq_rx_o | output | 1 | One-cycle packet-received pulse |
| ovw_o | output | 1 | One-cycle overwrite warning pulse |
| cur_page_o | output | PW | Current page (write pointer) |
| bnd_page_o | output | PW | Boundary page (read pointer) |
| ring_empty_o | output | 1 | Ring holds no unread frame |

## Verification
Two things can land on the same clock edge. The first is a host write to the boundary, arriving in the cycle a payload byte enters a new page. The second is a host write to the current page, arriving in the cycle a frame commit moves the same register. The bench drives its stimulus cycle by cycle, so it can place the host write on the exact negedge before the edge that takes byte 252 (offset 0 of the second page) or the fourth header write. In one case it moves the boundary onto the page being entered, and in the other it moves the boundary off that page. The result is judged at the ports: whether the warning or the interrupt pulses, the value of the current page afterwards, and the header found in the memory model.

// File: rtl/pgring_pkg.sv
package pgring_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FILL = 2'd1,
        ST_DROP = 2'd2,
        ST_HDR  = 2'd3
    } fill_st_e;

    localparam int unsigned STAT_BIT_INTACT = 0;
    localparam int unsigned STAT_BIT_FOVR   = 3;
    localparam int unsigned HDR_BYTES       = 4;

    localparam logic [1:0] SEL_START = 2'd0;
    localparam logic [1:0] SEL_STOP  = 2'd1;
    localparam logic [1:0] SEL_BND   = 2'd2;
    localparam logic [1:0] SEL_CUR   = 2'd3;

endpackage

// File: rtl/pgring_wrap.sv
// Page successor inside the ring: one past the page, folded to start at stop.
module pgring_wrap #(
    parameter int unsigned PW = 8
) (
    input  logic [PW-1:0] pg_i,
    input  logic [PW-1:0] start_i,
    input  logic [PW-1:0] stop_i,
    output logic [PW-1:0] nxt_o
);
    logic [PW-1:0] inc;

    always_comb begin
        inc   = pg_i + 1'b1;
        nxt_o = (inc == stop_i) ? start_i : inc;
    end
endmodule

// File: rtl/pgring_hdr_sel.sv
// Picks the header byte for a given header slot.
module pgring_hdr_sel #(
    parameter int unsigned DW = 8,
    parameter int unsigned PW = 8
) (
    input  logic [1:0]      idx_i,
    input  logic [DW-1:0]   status_i,
    input  logic [PW-1:0]   nxt_i,
    input  logic [2*DW-1:0] cnt_i,
    output logic [DW-1:0]   byte_o
);
    always_comb begin
        case (idx_i)
            2'd0:    byte_o = status_i;
            2'd1:    byte_o = DW'(nxt_i);
            2'd2:    byte_o = cnt_i[DW-1:0];
            default: byte_o = cnt_i[2*DW-1:DW];
        endcase
    end
endmodule

// File: rtl/pgring_rx.sv
module pgring_rx
    import pgring_pkg::*;
#(
    parameter int unsigned   PW        = 8,
    parameter int unsigned   OW        = 8,
    parameter int unsigned   DW        = 8,
    parameter logic [PW-1:0] RST_START = 8'h40,
    parameter logic [PW-1:0] RST_STOP  = 8'h80
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             rx_valid_i,
    input  logic [DW-1:0]    rx_data_i,
    input  logic             rx_eof_i,
    input  logic             rx_good_i,
    input  logic             rx_fovr_i,
    input  logic             host_we_i,
    input  logic [1:0]       host_sel_i,
    input  logic [PW-1:0]    host_wdata_i,
    output logic             mem_we_o,
    output logic [PW+OW-1:0] mem_addr_o,
    output logic [DW-1:0]    mem_wdata_o,
    output logic             irq_rx_o,
    output logic             ovw_o,
    output logic [PW-1:0]    cur_page_o,
    output logic [PW-1:0]    bnd_page_o,
    output logic             ring_empty_o
);
    localparam int unsigned AW = PW + OW;
    localparam int unsigned CW = 2 * DW;
    localparam logic [OW-1:0] HDR_OFS   = OW'(HDR_BYTES);
    localparam logic [OW-1:0] OFS_LAST  = {OW{1'b1}};

    typedef struct packed {
        fill_st_e      st;
        logic [PW-1:0] start;
        logic [PW-1:0] stop;
        logic [PW-1:0] bnd;
        logic [PW-1:0] cur;
        logic [PW-1:0] wpg;
        logic [PW-1:0] nxt;
        logic [OW-1:0] woff;
        logic [CW-1:0] cnt;
        logic [1:0]    hidx;
        logic [DW-1:0] status;
        logic          irq;
        logic          ovw;
        logic          mwe;
        logic [AW-1:0] maddr;
        logic [DW-1:0] mdat;
    } ring_t;

    ring_t r_d, r_q;

    logic [PW-1:0] wpg_inc;
    logic [PW-1:0] bnd_inc;
    logic [DW-1:0] hdr_byte;

    pgring_wrap #(.PW(PW)) u_wp_wrap (
        .pg_i    (r_q.wpg),
        .start_i (r_q.start),
        .stop_i  (r_q.stop),
        .nxt_o   (wpg_inc)
    );

    pgring_wrap #(.PW(PW)) u_bnd_wrap (
        .pg_i    (r_q.bnd),
        .start_i (r_q.start),
        .stop_i  (r_q.stop),
        .nxt_o   (bnd_inc)
    );

    pgring_hdr_sel #(.DW(DW), .PW(PW)) u_hdr_sel (
        .idx_i    (r_q.hidx),
        .status_i (r_q.status),
        .nxt_i    (r_q.nxt),
        .cnt_i    (r_q.cnt),
        .byte_o   (hdr_byte)
    );

    always_comb begin
        r_d     = r_q;
        r_d.irq = 1'b0;
        r_d.ovw = 1'b0;
        r_d.mwe = 1'b0;

        // Host register writes; a commit below may override the current page.
        if (host_we_i) begin
            case (host_sel_i)
                SEL_START: r_d.start = host_wdata_i;
                SEL_STOP:  r_d.stop  = host_wdata_i;
                SEL_BND:   r_d.bnd   = host_wdata_i;
                default:   r_d.cur   = host_wdata_i;
            endcase
        end

        case (r_q.st)
            ST_IDLE: begin
                if (rx_valid_i) begin
                    r_d.mwe   = 1'b1;
                    r_d.maddr = {r_q.cur, HDR_OFS};
                    r_d.mdat  = rx_data_i;
                    r_d.wpg   = r_q.cur;
                    r_d.woff  = HDR_OFS + 1'b1;
                    r_d.cnt   = CW'(HDR_BYTES + 1);
                    r_d.st    = ST_FILL;
                end
            end
            ST_FILL: begin
                if (rx_eof_i) begin
                    if (rx_good_i) begin
                        r_d.status                  = '0;
                        r_d.status[STAT_BIT_INTACT] = 1'b1;
                        r_d.status[STAT_BIT_FOVR]   = rx_fovr_i;
                        // An untouched fresh page is not claimed.
                        r_d.nxt  = (r_q.woff == '0) ? r_q.wpg : wpg_inc;
                        r_d.hidx = 2'd0;
                        r_d.st   = ST_HDR;
                    end else begin
                        r_d.st = ST_IDLE;
                    end
                end else if (rx_valid_i) begin
                    if ((r_q.woff == '0) && (r_q.wpg == r_q.bnd)) begin
                        r_d.ovw = 1'b1;
                        r_d.st  = ST_DROP;
                    end else begin
                        r_d.mwe   = 1'b1;
                        r_d.maddr = {r_q.wpg, r_q.woff};
                        r_d.mdat  = rx_data_i;
                        r_d.cnt   = r_q.cnt + 1'b1;
                        r_d.woff  = r_q.woff + 1'b1;
                        if (r_q.woff == OFS_LAST) begin
                            r_d.wpg = wpg_inc;
                        end
                    end
                end
            end
            ST_DROP: begin
                if (rx_eof_i) begin
                    r_d.st = ST_IDLE;
                end
            end
            default: begin
                r_d.mwe   = 1'b1;
                r_d.maddr = {r_q.cur, {(OW-2){1'b0}}, r_q.hidx};
                r_d.mdat  = hdr_byte;
                r_d.hidx  = r_q.hidx + 1'b1;
                if (r_q.hidx == 2'd3) begin
                    r_d.cur = r_q.nxt;
                    r_d.irq = 1'b1;
                    r_d.st  = ST_IDLE;
                end
            end
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            r_q       <= '0;
            r_q.st    <= ST_IDLE;
            r_q.start <= RST_START;
            r_q.stop  <= RST_STOP;
            r_q.bnd   <= RST_START;
            r_q.cur   <= RST_START + 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign mem_we_o     = r_q.mwe;
    assign mem_addr_o   = r_q.maddr;
    assign mem_wdata_o  = r_q.mdat;
    assign irq_rx_o     = r_q.irq;
    assign ovw_o        = r_q.ovw;
    assign cur_page_o   = r_q.cur;
    assign bnd_page_o   = r_q.bnd;
    assign ring_empty_o = (r_q.cur == bnd_inc);

endmodule

// File: rtl/pgring_rx_chk.sv
module pgring_rx_chk #(
    parameter int unsigned PW = 8
) (
    input logic          clk_i,
    input logic          rst_ni,
    input logic          irq_rx_o,
    input logic          ovw_o,
    input logic [PW-1:0] cur_page_o,
    input logic          host_we_i,
    input logic [1:0]    host_sel_i
);
    AST_IRQ_SINGLE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_rx_o |=> !irq_rx_o); // R4

    AST_OVW_SINGLE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ovw_o |=> !ovw_o); // R6

    AST_OVW_WITHOUT_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ovw_o |-> !irq_rx_o); // R6

    AST_CUR_MOVES_ON_COMMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(cur_page_o) |-> (irq_rx_o || $past(host_we_i && (host_sel_i == 2'd3)))); // R5

endmodule

bind pgring_rx pgring_rx_chk #(.PW(PW)) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .irq_rx_o   (irq_rx_o),
    .ovw_o      (ovw_o),
    .cur_page_o (cur_page_o),
    .host_we_i  (host_we_i),
    .host_sel_i (host_sel_i)
);

// File: tb/pgring_rx_tb_top.sv
module pgring_rx_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = 8'h00;
    logic        rx_eof = 1'b0;
    logic        rx_good = 1'b0;
    logic        rx_fovr = 1'b0;
    logic        host_we = 1'b0;
    logic [1:0]  host_sel = 2'd0;
    logic [7:0]  host_wdata = 8'h00;
    logic        mem_we;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        irq_rx;
    logic        ovw;
    logic [7:0]  cur_page;
    logic [7:0]  bnd_page;
    logic        ring_empty;

    always #4 clk = ~clk;

    pgring_rx #(.PW(8), .OW(8), .DW(8), .RST_START(8'h40), .RST_STOP(8'h46)) dut_i (
        .clk_i(clk), .rst_ni(rst_n),
        .rx_valid_i(rx_valid), .rx_data_i(rx_data), .rx_eof_i(rx_eof),
        .rx_good_i(rx_good), .rx_fovr_i(rx_fovr),
        .host_we_i(host_we), .host_sel_i(host_sel), .host_wdata_i(host_wdata),
        .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
        .irq_rx_o(irq_rx), .ovw_o(ovw), .cur_page_o(cur_page),
        .bnd_page_o(bnd_page), .ring_empty_o(ring_empty)
    );

    logic [7:0] mem [0:65535];
    always @(posedge clk) if (mem_we) mem[mem_addr] <= mem_wdata;

    int irq_cnt = 0;
    int ovw_cnt = 0;
    always @(negedge clk) begin
        if (irq_rx) irq_cnt++;
        if (ovw) ovw_cnt++;
    end

    int checks = 0;
    int errors = 0;
    int rs = 8'h40;
    int re = 8'h46;
    int exp_cur;
    int exp_bnd;

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic int adv(int p, int n);
        return rs + (((p - rs) + n) % (re - rs));
    endfunction

    function automatic logic [7:0] pat(int seed, int k);
        return 8'((seed * 29) + (k * 7) + (k / 256));
    endfunction

    task automatic host_wr(logic [1:0] sel, int val);
        @(negedge clk);
        host_we = 1'b1; host_sel = sel; host_wdata = 8'(val);
        @(negedge clk);
        host_we = 1'b0;
    endtask

    // Drives one frame cycle by cycle; index len is the end strobe.
    // hw_at < 0 means no host write; otherwise one host write on that index.
    task automatic send_raw(int len, bit good, bit fovr, int seed,
                            int hw_at, logic [1:0] sel, int val);
        for (int idx = 0; idx < len + 12; idx++) begin
            @(negedge clk);
            rx_valid = (idx < len);
            rx_data  = (idx < len) ? pat(seed, idx) : 8'h00;
            rx_eof   = (idx == len);
            rx_good  = good;
            rx_fovr  = fovr;
            host_we  = (idx == hw_at);
            host_sel = sel;
            host_wdata = 8'(val);
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_eof = 1'b0; host_we = 1'b0;
    endtask

    function automatic bit will_ovf(int base, int cnt, int bnd);
        for (int j = 1; j * 256 < cnt; j++)
            if (adv(base, j) == bnd) return 1'b1;
        return 1'b0;
    endfunction

    // Checks a committed frame against the model; returns its next page.
    task automatic check_commit(int base, int len, bit fovr, int seed, string tag);
        int cnt; int nxt; int bad;
        cnt = len + 4;
        nxt = adv(base, (cnt + 255) / 256);
        chk(int'(cur_page) == nxt, {tag, " R4 next page"}, cur_page, nxt);
        chk(mem[{8'(base), 8'd0}] == (8'h01 | (fovr ? 8'h08 : 8'h00)), {tag, " R3 status"},
            mem[{8'(base), 8'd0}], 8'h01 | (fovr ? 8'h08 : 8'h00));
        chk(int'(mem[{8'(base), 8'd1}]) == nxt, {tag, " R3 next byte"}, mem[{8'(base), 8'd1}], nxt);
        chk(int'({mem[{8'(base), 8'd3}], mem[{8'(base), 8'd2}]}) == cnt, {tag, " R3 count"},
            {mem[{8'(base), 8'd3}], mem[{8'(base), 8'd2}]}, cnt);
        bad = 0;
        for (int k = 0; k < len; k++) begin
            int pos; int pg;
            pos = 4 + k;
            pg  = adv(base, pos / 256);
            if (mem[{8'(pg), 8'(pos % 256)}] != pat(seed, k)) bad++;
        end
        chk(bad == 0, {tag, " R2 payload"}, bad, 0);
        exp_cur = nxt;
    endtask

    task automatic free_all(string tag);
        int b;
        b = (exp_cur == rs) ? re - 1 : exp_cur - 1;
        host_wr(2'd2, b);
        exp_bnd = b;
        @(negedge clk);
        chk(ring_empty == 1'b1, {tag, " R7 empty after free"}, ring_empty, 1);
    endtask

    task automatic run_good(int len, bit fovr, int seed, string tag);
        int base; int i0; int o0; bit ovf;
        base = exp_cur;
        ovf = will_ovf(base, len + 4, exp_bnd);
        i0 = irq_cnt; o0 = ovw_cnt;
        send_raw(len, 1'b1, fovr, seed, -1, 2'd0, 0);
        if (ovf) begin
            chk(ovw_cnt - o0 == 1, {tag, " R6 warning"}, ovw_cnt - o0, 1);
            chk(irq_cnt - i0 == 0, {tag, " R6 no irq"}, irq_cnt - i0, 0);
            chk(int'(cur_page) == base, {tag, " R6 cur held"}, cur_page, base);
        end else begin
            chk(irq_cnt - i0 == 1, {tag, " R4 one irq"}, irq_cnt - i0, 1);
            chk(ovw_cnt - o0 == 0, {tag, " R9 no warning"}, ovw_cnt - o0, 0);
            check_commit(base, len, fovr, seed, tag);
            free_all(tag);
        end
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int base; int i0; int o0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(cur_page == 8'h41, "R1 cur", cur_page, 8'h41);
        chk(bnd_page == 8'h40, "R1 bnd", bnd_page, 8'h40);
        chk(ring_empty == 1'b1, "R1 empty", ring_empty, 1);
        chk(irq_rx == 1'b0 && ovw == 1'b0, "R1 pulses idle", {irq_rx, ovw}, 0);
        exp_cur = 8'h41; exp_bnd = 8'h40;

        // Length sweep, wrapping around the 6-page ring; last one overflows (R6).
        for (int i = 0; i < 10; i++) run_good(60 + i * 140, 1'b0, i, "sweep");
        // Exact page fill with boundary right behind (R9), then one byte more (R6).
        run_good(1276, 1'b0, 11, "R9 exact");
        run_good(1277, 1'b0, 12, "R6 one over");
        // FIFO-overrun bit in status (R3).
        run_good(80, 1'b1, 13, "R3 fovr");

        // Error frame (R5).
        base = exp_cur; i0 = irq_cnt;
        send_raw(100, 1'b0, 1'b0, 14, -1, 2'd0, 0);
        chk(int'(cur_page) == base, "R5 cur held", cur_page, base);
        chk(irq_cnt - i0 == 0, "R5 no irq", irq_cnt - i0, 0);
        run_good(70, 1'b0, 15, "R5 reuse");

        // Same cycle: boundary moved onto the entered page; old value rules (R8).
        base = exp_cur; i0 = irq_cnt; o0 = ovw_cnt;
        send_raw(400, 1'b1, 1'b0, 16, 252, 2'd2, adv(base, 1));
        chk(ovw_cnt - o0 == 0, "R8 old bnd no warning", ovw_cnt - o0, 0);
        chk(irq_cnt - i0 == 1, "R8 old bnd commit", irq_cnt - i0, 1);
        check_commit(base, 400, 1'b0, 16, "R8 A");
        free_all("R8 A");

        // Same cycle: boundary moved off the entered page; old value still rules (R8).
        base = exp_cur;
        host_wr(2'd2, adv(base, 1));
        i0 = irq_cnt; o0 = ovw_cnt;
        send_raw(400, 1'b1, 1'b0, 17, 252, 2'd2, exp_bnd);
        chk(ovw_cnt - o0 == 1, "R8 old bnd warning", ovw_cnt - o0, 1);
        chk(irq_cnt - i0 == 0, "R8 dropped no irq", irq_cnt - i0, 0);
        chk(int'(cur_page) == base, "R8 cur held", cur_page, base);
        chk(int'(bnd_page) == exp_bnd, "R8 bnd written", bnd_page, exp_bnd);

        // Commit overrides a same-cycle host write to the current page (R8).
        base = exp_cur; i0 = irq_cnt;
        send_raw(90, 1'b1, 1'b0, 18, 94, 2'd3, 8'h45);
        chk(irq_cnt - i0 == 1, "R8 commit irq", irq_cnt - i0, 1);
        check_commit(base, 90, 1'b0, 18, "R8 C");
        free_all("R8 C");

        // Host rewrites the ring bounds and pointers (R8), then a frame wraps at the new stop.
        host_wr(2'd1, 8'h44);
        host_wr(2'd3, 8'h42);
        host_wr(2'd2, 8'h41);
        rs = 8'h40; re = 8'h44; exp_cur = 8'h42; exp_bnd = 8'h41;
        @(negedge clk);
        chk(cur_page == 8'h42, "R8 cur write", cur_page, 8'h42);
        chk(ring_empty == 1'b1, "R7 empty rewritten", ring_empty, 1);
        run_good(600, 1'b0, 19, "R8 new stop");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule